// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the software-visible control state of one bus-master disk DMA channel. The state is a command byte, a status byte and a descriptor-table base address. Software reaches all three through a small byte-addressed register port that accepts 1-, 2- and 4-byte accesses. The block turns changes of the command's start bit into single-cycle start and stop pulses for a separate descriptor walker. It also keeps the walker's current table pointer, which is reloaded from the base address on every start and advanced by one descriptor on request.

The drive interrupt passes straight through to the interrupt output. A rising edge of that interrupt also sets a sticky status flag that software clears by writing a one to it. The walker reports three things back: completion, with or without more work pending, and table exhaustion. Completion without pending work drops the active flag. Exhaustion raises both the error flag and the interrupt flag.

Port map used by software: byte address 0 is the command byte, byte address 2 is the status byte, and byte addresses 4 to 7 hold the base address, least significant byte at address 4. Addresses 1 and 3 read as zero and ignore writes. The access size `acc_size` is encoded as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.

Top module: `bm_ctl_regs`

## Requirements
- R1: After reset the command byte, the status byte, the base address and the current pointer all read zero, and neither walker pulse is asserted.
- R2: A command write stores only bit 0 (start) and bit 3 (direction; the `dir_to_mem` output mirrors it). Every other bit reads back as zero.
- R3: A command write that changes start from 0 to 1 loads the current pointer from the base address. If the channel was not active, it also sets the active flag (status bit 0) and pulses `wk_start` for one cycle.
- R4: A command write whose start bit equals the stored start bit produces neither pulse. It leaves the active flag and the current pointer untouched.
- R5: A command write that changes start from 1 to 0 pulses `wk_stop` for one cycle and clears the active flag.
- R6: A rising edge on `drv_irq` sets the interrupt flag (status bit 2). `irq_out` follows `drv_irq` in both directions, and a falling edge leaves the flag set.
- R7: In the status byte, writing 1 to bit 1 (error) or bit 2 (interrupt) clears that bit. A set event in the same cycle wins over the clear. Bits 5 and 6 are plain read/write flags, and bit 0 ignores writes.
- R8: A base-address write updates only the addressed bytes that fall within addresses 4 to 7. Bits 1:0 of the base address always stay zero.
- R9: A base-address read returns the base shifted down by the byte offset (address minus 4) and masked to the access width.
- R10: `wk_done` with `wk_more` low clears the active flag. With `wk_more` high, the active flag is kept.
- R11: `wk_exhaust` sets both the error flag and the interrupt flag.
- R12: `wk_adv` adds the descriptor size (8) to the current pointer. A reload caused by a start in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 3 | Byte address of the access |
| acc_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, least significant byte at the addressed byte |
| acc_rdata | output | 32 | Read data for the addressed register |
| drv_irq | input | 1 | Interrupt request from the drive |
| irq_out | output | 1 | Interrupt forwarded to the system |
| wk_done | input | 1 | Walker finished a transfer |
| wk_more | input | 1 | Qualifies wk_done: more work pending |
| wk_exhaust | input | 1 | Walker ran out of descriptors |
| wk_adv | input | 1 | Walker consumed one descriptor |
| wk_start | output | 1 | One-cycle start pulse to the walker |
| wk_stop | output | 1 | One-cycle stop/cancel pulse to the walker |
| dma_active | output | 1 | Active flag (status bit 0) |
| dir_to_mem | output | 1 | Stored direction bit |
| cur_ptr | output | 32 | Current descriptor-table pointer |

## Verification
Each register is updated on the first rising edge after its access or walker event. From that same edge on, `wk_start`, `wk_stop`, `dma_active`, `cur_ptr` and every value seen on `acc_rdata` reflect the new state. `irq_out` follows `drv_irq` within the same cycle, and internal reset release lags `rst_n` by two edges. The bench holds a behavioural model that steps once per rising edge from the inputs it drove. It compares every output on the following falling edge, so a result due one edge late, or one edge early, shows up as a miscompare.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;

  typedef enum logic [1:0] {
    RGN_CMD  = 2'd0,
    RGN_STAT = 2'd1,
    RGN_BASE = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;

  localparam int ST_ACT_BIT = 0;
  localparam int ST_ERR_BIT = 1;
  localparam int ST_INT_BIT = 2;
  localparam int ST_FA_BIT  = 5;
  localparam int ST_FB_BIT  = 6;

  function automatic rgn_e decode_rgn(input logic [2:0] a);
    if (a == 3'd0)      return RGN_CMD;
    else if (a == 3'd2) return RGN_STAT;
    else if (a[2])      return RGN_BASE;
    else                return RGN_NONE;
  endfunction

  function automatic logic [2:0] size_to_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bm_base_reg.sv
module bm_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    off,
  input  logic [1:0]    size,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] rd_val
);
  import bm_regs_pkg::*;

  localparam int NB = AW / 8;

  logic [2:0]    nbytes;
  logic [AW-1:0] wshift;
  logic [AW-1:0] rshift;
  logic [NB-1:0] lane_en;
  logic [AW-1:0] base_d;
  logic          base_en;

  assign nbytes  = size_to_bytes(size);
  assign wshift  = wdata << {off, 3'b000};
  assign rshift  = base_q >> {off, 3'b000};
  assign base_en = we;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_lane
      assign lane_en[gi] = (gi >= int'(off)) && (gi < int'(off) + int'(nbytes));
      if (gi == 0) begin : g_low
        assign base_d[7:0] = lane_en[0] ? {wshift[7:2], 2'b00} : base_q[7:0];
      end else begin : g_up
        assign base_d[8*gi +: 8] = lane_en[gi] ? wshift[8*gi +: 8] : base_q[8*gi +: 8];
      end
    end
  endgenerate

  always_comb begin
    case (nbytes)
      3'd1:    rd_val = {{(AW-8){1'b0}}, rshift[7:0]};
      3'd2:    rd_val = {{(AW-16){1'b0}}, rshift[15:0]};
      default: rd_val = rshift;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  // R8: without a write the base address must not move
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(base_q));

endmodule

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_wbyte,
  input  logic          wk_done,
  input  logic          wk_more,
  input  logic          wk_adv,
  input  logic [AW-1:0] base_q,
  output logic [7:0]    cmd_q,
  output logic          act_q,
  output logic          start_q,
  output logic          stop_q,
  output logic [AW-1:0] ptr_q
);
  import bm_regs_pkg::*;

  localparam logic [AW-1:0] PTR_STEP = AW'(DESC_BYTES);

  logic          go_changed, go_rise, go_fall;
  logic [7:0]    cmd_d;
  logic          act_d, start_d, stop_d;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    go_changed = cmd_we && (cmd_wbyte[CMD_GO_BIT] != cmd_q[CMD_GO_BIT]);
    go_rise    = go_changed && cmd_wbyte[CMD_GO_BIT];
    go_fall    = go_changed && !cmd_wbyte[CMD_GO_BIT];
    cmd_d      = cmd_wbyte & CMD_KEEP_MASK;

    if (go_fall)                act_d = 1'b0;
    else if (go_rise)           act_d = 1'b1;
    else if (wk_done && !wk_more) act_d = 1'b0;
    else                        act_d = act_q;

    start_d = go_rise && !act_q;
    stop_d  = go_fall;

    ptr_en = go_rise || wk_adv;
    ptr_d  = go_rise ? base_q : ptr_q + PTR_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      act_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_d;
      act_q   <= act_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // R3: a start pulse always coincides with an active channel
  assert_start_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> act_q);

  // R4: rewriting the same start value yields no pulse
  assert_same_go_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (cmd_wbyte[CMD_GO_BIT] == cmd_q[CMD_GO_BIT])) |=> (!start_q && !stop_q));

  // R5: a stop pulse leaves the channel inactive, never with a start
  assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!act_q && !start_q));

  // R10: completion without pending work drops the active flag
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_done && !wk_more && !cmd_we) |=> !act_q);

endmodule

// File: rtl/bm_status.sv
module bm_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_we,
  input  logic [1:0] w1c_bits,
  input  logic [1:0] flag_bits,
  input  logic       act,
  input  logic       drv_irq,
  input  logic       wk_exhaust,
  output logic [7:0] st_byte
);
  import bm_regs_pkg::*;

  logic       irq_d;
  logic       err_q, int_q;
  logic [1:0] flags_q;
  logic       err_set, int_set, err_clr, int_clr;
  logic       err_d, int_d;

  always_comb begin
    err_set = wk_exhaust;
    int_set = wk_exhaust || (drv_irq && !irq_d);
    err_clr = st_we && w1c_bits[0];
    int_clr = st_we && w1c_bits[1];
    err_d   = err_set ? 1'b1 : (err_clr ? 1'b0 : err_q);
    int_d   = int_set ? 1'b1 : (int_clr ? 1'b0 : int_q);

    st_byte             = '0;
    st_byte[ST_ACT_BIT] = act;
    st_byte[ST_ERR_BIT] = err_q;
    st_byte[ST_INT_BIT] = int_q;
    st_byte[ST_FA_BIT]  = flags_q[0];
    st_byte[ST_FB_BIT]  = flags_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d   <= 1'b0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      irq_d <= drv_irq;
      err_q <= err_d;
      int_q <= int_d;
      if (st_we) flags_q <= flag_bits;
    end
  end

  // R6: the interrupt flag stays until software clears it
  assert_int_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !(st_we && w1c_bits[1])) |=> int_q);

  // R11: exhaustion raises error and interrupt together
  assert_exhaust_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wk_exhaust |=> (err_q && int_q));

endmodule

// File: rtl/bm_ctl_regs.sv
module bm_ctl_regs #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic [2:0]    acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] acc_wdata,
  output logic [AW-1:0] acc_rdata,
  input  logic          drv_irq,
  output logic          irq_out,
  input  logic          wk_done,
  input  logic          wk_more,
  input  logic          wk_exhaust,
  input  logic          wk_adv,
  output logic          wk_start,
  output logic          wk_stop,
  output logic          dma_active,
  output logic          dir_to_mem,
  output logic [AW-1:0] cur_ptr
);
  import bm_regs_pkg::*;

  logic [1:0]    rst_pipe;
  logic          rst_ni;
  rgn_e          rgn;
  logic          cmd_we, st_we, base_we;
  logic [7:0]    cmd_q, st_byte;
  logic [AW-1:0] base_q, base_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign rgn     = decode_rgn(acc_addr);
  assign cmd_we  = acc_wr && (rgn == RGN_CMD);
  assign st_we   = acc_wr && (rgn == RGN_STAT);
  assign base_we = acc_wr && (rgn == RGN_BASE);

  bm_base_reg #(.AW(AW)) base_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .we     (base_we),
    .off    (acc_addr[1:0]),
    .size   (acc_size),
    .wdata  (acc_wdata),
    .base_q (base_q),
    .rd_val (base_rd)
  );

  bm_cmd_ctl #(.AW(AW), .DESC_BYTES(DESC_BYTES)) cmd_i (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cmd_we    (cmd_we),
    .cmd_wbyte (acc_wdata[7:0]),
    .wk_done   (wk_done),
    .wk_more   (wk_more),
    .wk_adv    (wk_adv),
    .base_q    (base_q),
    .cmd_q     (cmd_q),
    .act_q     (dma_active),
    .start_q   (wk_start),
    .stop_q    (wk_stop),
    .ptr_q     (cur_ptr)
  );

  bm_status stat_i (
    .clk        (clk),
    .rst_n      (rst_ni),
    .st_we      (st_we),
    .w1c_bits   (acc_wdata[ST_INT_BIT:ST_ERR_BIT]),
    .flag_bits  (acc_wdata[ST_FB_BIT:ST_FA_BIT]),
    .act        (dma_active),
    .drv_irq    (drv_irq),
    .wk_exhaust (wk_exhaust),
    .st_byte    (st_byte)
  );

  assign irq_out    = drv_irq;
  assign dir_to_mem = cmd_q[CMD_DIR_BIT];

  always_comb begin
    case (rgn)
      RGN_CMD:  acc_rdata = {{(AW-8){1'b0}}, cmd_q};
      RGN_STAT: acc_rdata = {{(AW-8){1'b0}}, st_byte};
      RGN_BASE: acc_rdata = base_rd;
      default:  acc_rdata = '0;
    endcase
  end

  // R3: the pointer handed to the walker at start is the base address
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    wk_start |-> (cur_ptr == base_q));

  // R2: only start and direction survive in the command byte
  assert_cmd_mask_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q & ~CMD_KEEP_MASK) == 8'h00);

endmodule

// File: tb/bm_ctl_regs_tb.sv
module bm_ctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_wr;
  logic [2:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        drv_irq, irq_out;
  logic        wk_done, wk_more, wk_exhaust, wk_adv;
  logic        wk_start, wk_stop, dma_active, dir_to_mem;
  logic [31:0] cur_ptr;

  always #10 clk = ~clk;

  bm_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .drv_irq(drv_irq), .irq_out(irq_out), .wk_done(wk_done),
    .wk_more(wk_more), .wk_exhaust(wk_exhaust), .wk_adv(wk_adv),
    .wk_start(wk_start), .wk_stop(wk_stop), .dma_active(dma_active),
    .dir_to_mem(dir_to_mem), .cur_ptr(cur_ptr)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0]  m_cmd;
  logic        m_act, m_err, m_int, m_fa, m_fb, m_prev_irq;
  logic        m_start, m_stop;
  logic [31:0] m_base, m_ptr;

  task automatic model_reset();
    m_cmd = 0; m_act = 0; m_err = 0; m_int = 0; m_fa = 0; m_fb = 0;
    m_prev_irq = 0; m_start = 0; m_stop = 0; m_base = 0; m_ptr = 0;
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_rdata();
    int off;
    logic [31:0] v;
    if (acc_addr == 0) return {24'h0, m_cmd};
    if (acc_addr == 2) return {25'h0, m_fb, m_fa, 2'b00, m_int, m_err, m_act};
    if (acc_addr >= 4) begin
      off = int'(acc_addr) - 4;
      v = m_base >> (8 * off);
      if (nbytes(acc_size) == 1) v = v & 32'hFF;
      else if (nbytes(acc_size) == 2) v = v & 32'hFFFF;
      return v;
    end
    return 0;
  endfunction

  task automatic model_step();
    logic ev_up, ev_down, irq_edge;
    int off;
    ev_up = 0; ev_down = 0;
    irq_edge = drv_irq && !m_prev_irq;
    m_start = 0; m_stop = 0;
    if (acc_wr && acc_addr == 0) begin
      if (acc_wdata[0] && !m_cmd[0]) ev_up = 1;
      if (!acc_wdata[0] && m_cmd[0]) ev_down = 1;
      m_cmd = acc_wdata[7:0] & 8'h09;
    end
    if (ev_up) begin
      m_ptr = m_base;
      if (!m_act) m_start = 1;
    end else if (wk_adv) begin
      m_ptr = m_ptr + 8;
    end
    if (ev_down) begin m_stop = 1; m_act = 0; end
    else if (ev_up) m_act = 1;
    else if (wk_done && !wk_more) m_act = 0;
    if (wk_exhaust) m_err = 1;
    else if (acc_wr && acc_addr == 2 && acc_wdata[1]) m_err = 0;
    if (wk_exhaust || irq_edge) m_int = 1;
    else if (acc_wr && acc_addr == 2 && acc_wdata[2]) m_int = 0;
    if (acc_wr && acc_addr == 2) begin m_fa = acc_wdata[5]; m_fb = acc_wdata[6]; end
    m_prev_irq = drv_irq;
    if (acc_wr && acc_addr >= 4) begin
      off = int'(acc_addr) - 4;
      for (int i = 0; i < 4; i++)
        if (i >= off && i < off + nbytes(acc_size))
          m_base[8*i +: 8] = acc_wdata[8*(i-off) +: 8];
      m_base[1:0] = 2'b00;
    end
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "acc_rdata (R9)", acc_rdata, exp_rdata());
    chk(tag, "dma_active (R3)", {31'h0, dma_active}, {31'h0, m_act});
    chk(tag, "wk_start (R3)", {31'h0, wk_start}, {31'h0, m_start});
    chk(tag, "wk_stop (R5)", {31'h0, wk_stop}, {31'h0, m_stop});
    chk(tag, "cur_ptr (R12)", cur_ptr, m_ptr);
    chk(tag, "irq_out (R6)", {31'h0, irq_out}, {31'h0, drv_irq});
    chk(tag, "dir_to_mem (R2)", {31'h0, dir_to_mem}, {31'h0, m_cmd[3]});
  endtask

  // one clock: model follows the edge, outputs compared on the falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    acc_wr = 0; acc_addr = 3'd1; acc_size = 0; acc_wdata = 0;
    wk_done = 0; wk_more = 0; wk_exhaust = 0; wk_adv = 0;
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    acc_wr = 1; acc_addr = a; acc_size = s; acc_wdata = d;
    tick(tag);
    idle();
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [1:0] s);
    acc_wr = 0; acc_addr = a; acc_size = s;
    tick(tag);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; drv_irq = 0;
    idle();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state, including two-edge synchronised release
    repeat (4) tick("R1");
    rd("R1", 3'd0, 2'd0);
    rd("R1", 3'd2, 2'd0);
    rd("R1", 3'd4, 2'd2);

    // R8 R9: base address lanes and reads
    wr("R8", 3'd4, 2'd2, 32'h12345677);
    rd("R9", 3'd4, 2'd2);
    rd("R9", 3'd4, 2'd1);
    rd("R9", 3'd5, 2'd0);
    rd("R9", 3'd6, 2'd1);
    rd("R9", 3'd7, 2'd2);
    wr("R8", 3'd4, 2'd0, 32'h000000FF);
    wr("R8", 3'd6, 2'd1, 32'h0000ABCD);
    rd("R8", 3'd4, 2'd3);
    wr("R8", 3'd6, 2'd2, 32'h11223344);
    rd("R8", 3'd4, 2'd2);
    wr("R8", 3'd1, 2'd2, 32'hFFFFFFFF);
    rd("R8", 3'd4, 2'd2);

    // R2 R3: start with masked command byte
    wr("R3", 3'd0, 2'd0, 32'h000000FF);
    rd("R2", 3'd0, 2'd0);
    // R12: advance three descriptors
    wk_adv = 1; tick("R12"); tick("R12"); tick("R12"); idle();
    // R4: same start value, direction change only
    wr("R4", 3'd0, 2'd0, 32'h00000001);
    wr("R4", 3'd0, 2'd0, 32'h00000009);
    rd("R4", 3'd2, 2'd0);
    // R10: done with more pending keeps active, without clears
    wk_done = 1; wk_more = 1; tick("R10"); idle();
    wk_done = 1; wk_more = 0; tick("R10"); idle();
    wr("R4", 3'd0, 2'd0, 32'h00000001);
    // R5: stop
    wr("R5", 3'd0, 2'd0, 32'h00000000);
    wr("R5", 3'd0, 2'd0, 32'h00000000);
    // R12: start and advance in one cycle, reload wins
    wk_adv = 1; wr("R12", 3'd0, 2'd0, 32'h00000001);
    wr("R5", 3'd0, 2'd0, 32'h00000000);

    // R6: interrupt edge, pass-through both ways
    drv_irq = 1; tick("R6"); tick("R6");
    drv_irq = 0; tick("R6");
    rd("R6", 3'd2, 2'd0);
    // R7: W1C interrupt, flags, active bit read-only
    wr("R7", 3'd2, 2'd0, 32'h00000004);
    rd("R7", 3'd2, 2'd0);
    wr("R7", 3'd2, 2'd0, 32'h00000061);
    rd("R7", 3'd2, 2'd0);
    // R11: exhaustion sets error and interrupt
    wk_exhaust = 1; tick("R11"); idle();
    rd("R11", 3'd2, 2'd0);
    wr("R7", 3'd2, 2'd0, 32'h00000002);
    rd("R7", 3'd2, 2'd0);
    // R7: set wins over same-cycle clear
    wk_exhaust = 1; wr("R7", 3'd2, 2'd0, 32'h00000006);
    rd("R7", 3'd2, 2'd0);
    drv_irq = 1; wr("R7", 3'd2, 2'd0, 32'h00000004);
    drv_irq = 0; rd("R7", 3'd2, 2'd0);

    // mixed traffic over all requirements
    for (int k = 0; k < 600; k++) begin
      acc_wr     = ($urandom % 3) == 0;
      acc_addr   = 3'($urandom);
      acc_size   = 2'($urandom);
      acc_wdata  = $urandom;
      drv_irq    = ($urandom % 4) == 0 ? ~drv_irq : drv_irq;
      wk_done    = ($urandom % 8) == 0;
      wk_more    = $urandom % 2;
      wk_exhaust = ($urandom % 16) == 0;
      wk_adv     = ($urandom % 5) == 0;
      tick("R1-mix R3 R5 R7 R12");
    end
    idle();
    drv_irq = 0;
    tick("R6");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule